// File: doc/BRIEF.md
# Host Byte Port Status and Word Transfer Logic

This block sits between an external host processor with an 8-bit bus and a 16-bit DSP core. The host moves a 16-bit word toward the DSP by writing a high byte and then a low byte. It reads a DSP word as two bytes. On the DSP side, a 16-bit outbound register is filled by a write strobe, and a 16-bit inbound register is emptied by a read strobe.

Each of the two word transfers runs on its own, inside the block. Two status flags follow the transfers. The receive-full flag is set when a DSP word lands in the host read bytes, and it is cleared by a host read of the low byte. The transmit-empty flag is set when the host byte pair moves into the DSP inbound register, and it is cleared by a host write of the low byte. A ready bit shows that the whole host-to-DSP path is empty. A request output, gated separately for each direction, can interrupt the host. A one-cycle initialize command returns both flags to their idle values.

Top module: `hostport_status`

## Requirements
- R1: A host read at address 2 returns the status byte: bit 0 receive-full, bit 1 transmit-empty, bit 2 transmitter-ready, bit 7 request output, bits 3 to 6 zero. Addresses 3, 6 and 7 read as zero.
- R2: After reset, receive-full is 0, transmit-empty is 1, the control register is 0, and both DSP-side registers are empty, so the status reads 0x06 and the request output is low.
- R3: While the DSP outbound register holds data, receive-full is clear and no initialize is in progress, the next clock edge does three things: it copies the word into the host read bytes (high byte at address 4, low byte at address 5), sets receive-full, and marks the outbound register empty (`d_tx_full` low). A DSP write in that same cycle refills the register.
- R4: A host read of address 5 clears receive-full at the next edge. The read bytes keep their values.
- R5: A host write to address 5 clears transmit-empty. On a later edge where transmit-empty is 0 and the DSP inbound register is empty, the word {byte at 4, byte at 5} moves to `d_rx_data`, `d_rx_full` rises and transmit-empty returns to 1. While `d_rx_full` is high the word waits, until a `d_rx_rd` pulse empties the register.
- R6: Transmitter-ready is 1 exactly when transmit-empty is 1 and `d_rx_full` is 0.
- R7: The control register at address 0 is written and read as a full byte. Bit 0 enables the receive request and bit 1 enables the transmit request. `h_req` = (receive-full AND bit 0) OR (transmit-empty AND bit 1).
- R8: The status flags show their true values whatever the request enables are set to.
- R9: A write to address 1 with bit 7 set performs initialize. At the next edge, receive-full is 0 and transmit-empty is 1, and neither word transfer happens in that cycle. A write to address 1 with bit 7 clear changes nothing.
- R10: A host read of address 4 or a host write of address 4 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 3 | Host register address |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational on `h_addr` |
| h_req | output | 1 | Host request output |
| d_tx_wr | input | 1 | DSP load strobe for the outbound word |
| d_tx_data | input | 16 | DSP outbound word |
| d_tx_full | output | 1 | DSP outbound register holds a word |
| d_rx_rd | input | 1 | DSP read strobe that empties the inbound register |
| d_rx_data | output | 16 | DSP inbound word |
| d_rx_full | output | 1 | DSP inbound register holds a word |

## Verification
The hardest case to reach from the ports is a host word that has to wait. It arises when a second host word is written while the DSP still holds the first one unread. The stalled transfer must then resume on the edge after `d_rx_rd`, and it may collide with an initialize or with a new low-byte write. The stimulus has two parts. A directed sequence builds this stall on purpose. Random phases then hold the DSP read probability very low in one phase and high in the other, and they mix in random writes to address 1 whose bit 7 is set about half the time.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  localparam int STAT_W = 8;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI   = 3'd4;
  localparam logic [ADDR_W-1:0] A_LO   = 3'd5;
  localparam int INIT_BIT   = 7;
  localparam int RX_EN_BIT  = 0;
  localparam int TX_EN_BIT  = 1;

  // status byte: request on top, path-ready / tx-empty / rx-full at the bottom
  function automatic logic [STAT_W-1:0] pack_status(input logic rxdf, input logic txde,
                                                   input logic trdy, input logic hreq);
    return {hreq, 4'b0000, trdy, txde, rxdf};
  endfunction

  function automatic logic path_ready(input logic txde, input logic dsp_full);
    return txde & ~dsp_full;
  endfunction

  function automatic logic req_out(input logic rxdf, input logic txde,
                                   input logic rx_en, input logic tx_en);
    return (rxdf & rx_en) | (txde & tx_en);
  endfunction
endpackage

// File: rtl/hp_tx_path.sv
module hp_tx_path #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_hi_i,
  input  logic                  wr_lo_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic                  init_i,
  input  logic                  d_rx_rd_i,
  output logic                  txde_o,
  output logic                  d_rx_full_o,
  output logic [2*BYTE_W-1:0]   d_rx_data_o,
  output logic                  xfer_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] hi_q, lo_q;
  logic [WORD_W-1:0] word_q;
  logic              txde_q, full_q;
  logic              xfer;

  // move the byte pair inward when it is pending and the DSP side is free
  assign xfer = ~txde_q & ~full_q & ~init_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      word_q <= '0;
      txde_q <= 1'b1;
      full_q <= 1'b0;
    end else begin
      if (wr_hi_i) hi_q <= wdata_i;
      if (wr_lo_i) lo_q <= wdata_i;
      if (init_i)       txde_q <= 1'b1;
      else if (wr_lo_i) txde_q <= 1'b0;
      else if (xfer)    txde_q <= 1'b1;
      if (xfer) begin
        word_q <= {hi_q, lo_q};
        full_q <= 1'b1;
      end else if (d_rx_rd_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign txde_o      = txde_q;
  assign d_rx_full_o = full_q;
  assign d_rx_data_o = word_q;
  assign xfer_o      = xfer;

  // R5
  tx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!txde_o && !d_rx_full_o && !init_i && !wr_lo_i) |=> (txde_o && d_rx_full_o));
  // R5
  tx_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!txde_o && d_rx_full_o && !d_rx_rd_i && !init_i) |=> (!txde_o && d_rx_full_o));
  // R9
  tx_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> txde_o);
endmodule

// File: rtl/hp_rx_path.sv
module hp_rx_path #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  d_tx_wr_i,
  input  logic [2*BYTE_W-1:0]   d_tx_data_i,
  input  logic                  rd_lo_i,
  input  logic                  init_i,
  output logic                  rxdf_o,
  output logic                  d_tx_full_o,
  output logic [BYTE_W-1:0]     rx_hi_o,
  output logic [BYTE_W-1:0]     rx_lo_o,
  output logic                  xfer_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] out_q;
  logic [BYTE_W-1:0] rhi_q, rlo_q;
  logic              out_full_q, rxdf_q;
  logic              xfer;

  assign xfer = out_full_q & ~rxdf_q & ~init_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q      <= '0;
      out_full_q <= 1'b0;
      rhi_q      <= '0;
      rlo_q      <= '0;
      rxdf_q     <= 1'b0;
    end else begin
      if (d_tx_wr_i) begin
        out_q      <= d_tx_data_i;
        out_full_q <= 1'b1;
      end else if (xfer) begin
        out_full_q <= 1'b0;
      end
      if (xfer) begin
        rhi_q <= out_q[WORD_W-1:BYTE_W];
        rlo_q <= out_q[BYTE_W-1:0];
      end
      if (init_i)       rxdf_q <= 1'b0;
      else if (xfer)    rxdf_q <= 1'b1;
      else if (rd_lo_i) rxdf_q <= 1'b0;
    end
  end

  assign rxdf_o      = rxdf_q;
  assign d_tx_full_o = out_full_q;
  assign rx_hi_o     = rhi_q;
  assign rx_lo_o     = rlo_q;
  assign xfer_o      = xfer;

  // R3
  rx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_tx_full_o && !rxdf_o && !init_i) |=> rxdf_o);
  // R3
  rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_tx_full_o && !rxdf_o && !init_i && !d_tx_wr_i) |=> !d_tx_full_o);
  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxdf_o && rd_lo_i) |=> !rxdf_o);
  // R9
  rx_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> !rxdf_o);
endmodule

// File: rtl/hp_host_regs.sv
module hp_host_regs
  import hostport_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rxdf_i,
  input  logic              txde_i,
  input  logic              dsp_full_i,
  input  logic [BYTE_W-1:0] rx_hi_i,
  input  logic [BYTE_W-1:0] rx_lo_i,
  output logic              wr_hi_o,
  output logic              wr_lo_o,
  output logic              rd_lo_o,
  output logic              init_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              req_o
);
  logic [BYTE_W-1:0] ctrl_q;
  logic              trdy;
  logic [STAT_W-1:0] status;

  assign wr_hi_o = wr_i & (addr_i == A_HI);
  assign wr_lo_o = wr_i & (addr_i == A_LO);
  assign rd_lo_o = rd_i & (addr_i == A_LO);
  assign init_o  = wr_i & (addr_i == A_CMD) & wdata_i[INIT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (wr_i && addr_i == A_CTRL)   ctrl_q <= wdata_i;
  end

  assign trdy   = path_ready(txde_i, dsp_full_i);
  assign req_o  = req_out(rxdf_i, txde_i, ctrl_q[RX_EN_BIT], ctrl_q[TX_EN_BIT]);
  assign status = pack_status(rxdf_i, txde_i, trdy, req_o);

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_STAT:  rdata_o = BYTE_W'(status);
      A_HI:    rdata_o = rx_hi_i;
      A_LO:    rdata_o = rx_lo_i;
      default: rdata_o = '0;
    endcase
  end

  // R7
  req_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxdf_i && ctrl_q[RX_EN_BIT]) |-> req_o);
  // R7
  req_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txde_i && ctrl_q[TX_EN_BIT]) |-> req_o);
  // R7
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxdf_i && !txde_i) |-> !req_o);
endmodule

// File: rtl/hostport_status.sv
module hostport_status
  import hostport_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          h_addr,
  input  logic                h_wr,
  input  logic                h_rd,
  input  logic [BYTE_W-1:0]   h_wdata,
  output logic [BYTE_W-1:0]   h_rdata,
  output logic                h_req,
  input  logic                d_tx_wr,
  input  logic [2*BYTE_W-1:0] d_tx_data,
  output logic                d_tx_full,
  input  logic                d_rx_rd,
  output logic [2*BYTE_W-1:0] d_rx_data,
  output logic                d_rx_full
);
  logic wr_hi, wr_lo, rd_lo, init;
  logic txde, rxdf;
  logic tx_move, rx_move;
  logic [BYTE_W-1:0] rx_hi, rx_lo;

  hp_host_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(h_addr), .wr_i(h_wr), .rd_i(h_rd),
    .wdata_i(h_wdata), .rxdf_i(rxdf), .txde_i(txde), .dsp_full_i(d_rx_full),
    .rx_hi_i(rx_hi), .rx_lo_i(rx_lo), .wr_hi_o(wr_hi), .wr_lo_o(wr_lo),
    .rd_lo_o(rd_lo), .init_o(init), .rdata_o(h_rdata), .req_o(h_req)
  );

  hp_tx_path #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wdata_i(h_wdata),
    .init_i(init), .d_rx_rd_i(d_rx_rd), .txde_o(txde), .d_rx_full_o(d_rx_full),
    .d_rx_data_o(d_rx_data), .xfer_o(tx_move)
  );

  hp_rx_path #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .d_tx_wr_i(d_tx_wr), .d_tx_data_i(d_tx_data),
    .rd_lo_i(rd_lo), .init_i(init), .rxdf_o(rxdf), .d_tx_full_o(d_tx_full),
    .rx_hi_o(rx_hi), .rx_lo_o(rx_lo), .xfer_o(rx_move)
  );

  // R10
  hi_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_hi || (h_rd && h_addr == A_HI)) && txde && !init) |=> txde);
  // R10
  hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_addr == A_HI && rxdf && !init) |=> rxdf);
  // R5
  move_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_move |=> (d_rx_full && d_rx_data == $past({u_tx.hi_q, u_tx.lo_q})));
  // R3
  move_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_move |=> {rx_hi, rx_lo} == $past(u_rx.out_q));
endmodule

// File: tb/hostport_status_test.sv
module hostport_status_test;
  localparam int PERIOD = 10;
  localparam int WATCH_CYC = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  h_addr = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0]  h_wdata = '0;
  logic [7:0]  h_rdata;
  logic        h_req;
  logic        d_tx_wr = 1'b0;
  logic [15:0] d_tx_data = '0;
  logic        d_tx_full;
  logic        d_rx_rd = 1'b0;
  logic [15:0] d_rx_data;
  logic        d_rx_full;

  int total = 0;
  int bad = 0;

  // reference state
  logic        m_rxdf, m_txde, m_dfull, m_ofull;
  logic [7:0]  m_ctrl, m_th, m_tl, m_rh, m_rl;
  logic [15:0] m_dword, m_oword;

  always #(PERIOD/2) clk = ~clk;

  hostport_status uut (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_req(h_req), .d_tx_wr(d_tx_wr),
    .d_tx_data(d_tx_data), .d_tx_full(d_tx_full), .d_rx_rd(d_rx_rd),
    .d_rx_data(d_rx_data), .d_rx_full(d_rx_full)
  );

  function automatic logic [7:0] exp_status();
    logic rdy;
    logic rq;
    rdy = m_txde && !m_dfull;
    rq  = (m_ctrl[0] && m_rxdf) || (m_ctrl[1] && m_txde);
    return (8'(rq) << 7) | (8'(rdy) << 2) | (8'(m_txde) << 1) | 8'(m_rxdf);
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd2: return exp_status();
      3'd4: return m_rh;
      3'd5: return m_rl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic model_reset();
    m_rxdf = 0; m_txde = 1; m_dfull = 0; m_ofull = 0;
    m_ctrl = 0; m_th = 0; m_tl = 0; m_rh = 0; m_rl = 0;
    m_dword = 0; m_oword = 0;
  endtask

  task automatic model_step();
    logic ini, wlo, whi, rlo, go_in, go_out;
    ini = h_wr && h_addr == 3'd1 && h_wdata[7];
    wlo = h_wr && h_addr == 3'd5;
    whi = h_wr && h_addr == 3'd4;
    rlo = h_rd && h_addr == 3'd5;
    go_in  = !m_txde && !m_dfull && !ini;
    go_out = m_ofull && !m_rxdf && !ini;
    if (go_in) begin m_dword = {m_th, m_tl}; m_dfull = 1; end
    else if (d_rx_rd) m_dfull = 0;
    if (go_out) begin m_rh = m_oword[15:8]; m_rl = m_oword[7:0]; end
    if (d_tx_wr) begin m_oword = d_tx_data; m_ofull = 1; end
    else if (go_out) m_ofull = 0;
    if (ini) m_txde = 1; else if (wlo) m_txde = 0; else if (go_in) m_txde = 1;
    if (ini) m_rxdf = 0; else if (go_out) m_rxdf = 1; else if (rlo) m_rxdf = 0;
    if (whi) m_th = h_wdata;
    if (wlo) m_tl = h_wdata;
    if (h_wr && h_addr == 3'd0) m_ctrl = h_wdata;
  endtask

  task automatic compare_all();
    case (h_addr)
      3'd0: check("R7 ctrl read", h_rdata, exp_read(h_addr));
      3'd2: begin
        check("R1 status", h_rdata, exp_read(h_addr));
        check("R6 ready bit", h_rdata[2], m_txde && !m_dfull);
      end
      3'd4: check("R3 high byte", h_rdata, exp_read(h_addr));
      3'd5: check("R4 low byte", h_rdata, exp_read(h_addr));
      default: check("R1 empty address", h_rdata, exp_read(h_addr));
    endcase
    check("R7 h_req", h_req, exp_status() >> 7);
    check("R3 d_tx_full", d_tx_full, m_ofull);
    check("R5 d_rx_full", d_rx_full, m_dfull);
    if (m_dfull) check("R5 d_rx_data", d_rx_data, m_dword);
  endtask

  // one cycle: drive at negedge, compare, let the edge pass, advance the model
  task automatic cyc(input logic wr, input logic rd, input logic [2:0] a, input logic [7:0] wd,
                     input logic tw, input logic [15:0] td, input logic rr);
    @(negedge clk);
    h_wr = wr; h_rd = rd; h_addr = a; h_wdata = wd;
    d_tx_wr = tw; d_tx_data = td; d_rx_rd = rr;
    #1;
    compare_all();
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(); cyc(0, 0, 3'd2, 8'h00, 0, 16'h0, 0); endtask

  task automatic expect_status(input string tag, input logic [7:0] v);
    @(negedge clk);
    h_wr = 0; h_rd = 0; h_addr = 3'd2; d_tx_wr = 0; d_rx_rd = 0;
    #1;
    check(tag, h_rdata, v);
    compare_all();
    @(posedge clk);
    model_step();
  endtask

  task automatic random_phase(input int n, input int rd_pct);
    for (int i = 0; i < n; i++) begin
      logic [2:0] a;
      int op;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 3) ? 3'd2 : (pick < 6) ? 3'd5 : (pick < 7) ? 3'd4 :
          (pick < 8) ? 3'd0 : (pick < 9) ? 3'(($urandom_range(0, 1) == 0) ? 1 : 3) : 3'd6;
      op = $urandom_range(0, 2);
      cyc(op == 1, op == 2, a, 8'($urandom), $urandom_range(0, 99) < 20, 16'($urandom),
          $urandom_range(0, 99) < rd_pct);
    end
  endtask

  initial begin
    #(PERIOD * WATCH_CYC);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    h_addr = 3'd2;
    #1;
    check("R2 status in reset", h_rdata, 8'h06);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 status after reset", h_rdata, 8'h06);
    check("R2 h_req", h_req, 1'b0);
    check("R2 d_rx_full", d_rx_full, 1'b0);
    check("R2 d_tx_full", d_tx_full, 1'b0);
    h_addr = 3'd0;
    #1;
    check("R2 ctrl", h_rdata, 8'h00);

    // R8: DSP word arrives with both requests disabled
    cyc(0, 0, 3'd2, 8'h00, 1, 16'hA55A, 0);
    idle();
    expect_status("R8 rxdf polled", 8'h07);
    check("R8 h_req off", h_req, 1'b0);
    // R10: touching the high byte changes no flag
    cyc(0, 1, 3'd4, 8'h00, 0, 16'h0, 0);
    expect_status("R10 high read", 8'h07);
    cyc(1, 0, 3'd4, 8'h12, 0, 16'h0, 0);
    expect_status("R10 high write", 8'h07);
    // R4: low read clears rxdf
    cyc(0, 1, 3'd5, 8'h00, 0, 16'h0, 0);
    expect_status("R4 low read", 8'h06);
    // R5: word moves, second word stalls until DSP read
    cyc(1, 0, 3'd5, 8'h34, 0, 16'h0, 0);
    expect_status("R5 pending", 8'h00);
    expect_status("R5 delivered", 8'h02);
    check("R5 word", d_rx_data, 16'h1234);
    cyc(1, 0, 3'd4, 8'h56, 0, 16'h0, 0);
    cyc(1, 0, 3'd5, 8'h78, 0, 16'h0, 0);
    idle();
    expect_status("R5 stalled", 8'h00);
    check("R5 old word held", d_rx_data, 16'h1234);
    cyc(0, 0, 3'd2, 8'h00, 0, 16'h0, 1);
    idle();
    expect_status("R5 resumed", 8'h02);
    check("R5 second word", d_rx_data, 16'h5678);
    // R9: initialize discards a pending byte pair; bit 7 clear does nothing
    cyc(1, 0, 3'd5, 8'h9A, 0, 16'h0, 0);
    cyc(1, 0, 3'd1, 8'h7F, 0, 16'h0, 0);
    expect_status("R9 no init", 8'h00);
    cyc(1, 0, 3'd1, 8'h80, 0, 16'h0, 0);
    expect_status("R9 init", 8'h02);
    cyc(0, 0, 3'd2, 8'h00, 0, 16'h0, 1);
    idle();
    check("R9 pair discarded", d_rx_full, 1'b0);
    // R7: per-direction request gating
    cyc(1, 0, 3'd0, 8'h02, 0, 16'h0, 0);
    #1 check("R7 tx request", h_req, 1'b1);
    cyc(1, 0, 3'd0, 8'h01, 0, 16'h0, 0);
    #1 check("R7 rx request idle", h_req, 1'b0);

    random_phase(4000, 3);
    random_phase(4000, 60);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule